// File: doc/BRIEF.md
# Sticky Reset Cause Recorder

This block keeps a small set of flags that tell software why the system last came out of reset. Five causes are tracked: an external reset pin, power-on, brown-out, watchdog expiry and a software-requested reset. Each of the four non-power-on sources reaches the block as a one-cycle pulse sampled on the clock. Power-on arrives on a dedicated asynchronous active-low input, and it is the only event that initialises the flag storage. The ordinary system reset that follows the other causes does not touch the flags, so they build up across a chain of such resets.

Software reaches the flags through a plain 32-bit register port at one fixed byte offset. A read returns the flags in the same cycle. A write clears each flag whose data bit is 0 and keeps each flag whose data bit is 1, so a flag can be acknowledged without a read-modify-write race against the others. A hardware cause arriving in the same cycle as a clearing write wins, so a reset event is never lost. Generating resets, sequencing them and detecting watchdog or brown-out conditions are all done elsewhere.

Top module: `reset_cause_recorder`

## Requirements
- R1: While power-on (por_n low) is asserted, and right after it is released, the flags read 0x00000002: power-on flag (bit 1) set, every other flag clear.
- R2: A pulse on a cause input sets its flag at the next clock edge. The mapping is external bit 0, brown-out bit 2, watchdog bit 3, software bit 4.
- R3: The flags are sticky. A cause pulse leaves every flag set earlier unchanged, and with no write and no pulse every flag holds its value.
- R4: When several cause pulses arrive in one cycle, all of their flags are set.
- R5: A write at the register offset clears each of bits 4:0 whose write-data bit is 0 and keeps each one whose write-data bit is 1. This includes the power-on flag.
- R6: When a cause pulse and a write that would clear its flag fall in the same cycle, the flag ends up set.
- R7: A read at the register offset (default 0x05C) returns the flags in bits 4:0 in the same cycle. Bits 31:5 read 0, and write data in bits 31:5 has no effect.
- R8: A read at any other offset, or with the read strobe low, returns 0. A write at any other offset leaves the flags unchanged.
- R9: Asserting power-on in the middle of operation clears every flag except the power-on flag and sets that flag, whatever cause pulses are present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock on which cause pulses and writes are sampled |
| por_n | input | 1 | Asynchronous active-low power-on; initialises the flags |
| ext_rst_pulse | input | 1 | One-cycle pulse: external pin reset occurred |
| bor_rst_pulse | input | 1 | One-cycle pulse: brown-out reset occurred |
| wdt_rst_pulse | input | 1 | One-cycle pulse: watchdog reset occurred |
| sw_rst_pulse | input | 1 | One-cycle pulse: software reset occurred |
| reg_addr | input | ADDR_W (12) | Byte offset of the register access |
| reg_wr_en | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data; 0 clears a flag, 1 keeps it |
| reg_rd_en | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, combinational |

## Verification
A hardware cause pulse and a software clearing write can land in the same clock cycle, and the block must settle that collision in favour of the cause. The bench provokes it by sweeping every combination of the four cause pulses against every 5-bit write mask, with the write strobe both off and on. After each edge it compares the read-back value with a model that applies the write mask and then ORs in the pulse bits. Power-on raised while pulses are active is the second collision, and it is judged by expecting only the power-on flag.

// File: rtl/rc_pkg.sv
// Package: shared constants for the reset cause recorder.
// Assumes a 32-bit register and five cause flags at fixed bit positions.
package rc_pkg;
    localparam int REG_W      = 32;
    localparam int NUM_CAUSES = 5;

    // Bit positions of the cause flags in the register (software decodes these)
    localparam int IDX_EXT = 0;
    localparam int IDX_POR = 1;
    localparam int IDX_BOR = 2;
    localparam int IDX_WDT = 3;
    localparam int IDX_SW  = 4;

    typedef logic [NUM_CAUSES-1:0] cause_vec_t;

    // Flag value left by power-on: only the power-on flag set
    localparam cause_vec_t POR_FLAGS = cause_vec_t'(1) << IDX_POR;
endpackage

// File: rtl/rc_addr_match.sv
// Module: rc_addr_match
// Decodes a register access into read and write hits at one fixed byte offset.
// Assumes strobes are qualified by the full address comparison only.
module rc_addr_match #(
    parameter int                ADDR_W = 12,
    parameter logic [ADDR_W-1:0] OFFSET = 'h05C
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    output logic              rd_hit_o,
    output logic              wr_hit_o
);
    logic at_offset;

    // Compare the whole byte offset against the register location
    always_comb begin
        at_offset = (addr_i == OFFSET);
        rd_hit_o  = rd_en_i && at_offset;
        wr_hit_o  = wr_en_i && at_offset;
    end
endmodule

// File: rtl/rc_sticky_bit.sv
// Module: rc_sticky_bit
// One sticky flag: set by a hardware cause, cleared by a software write of 0.
// Assumes power-on is the only initialisation; a hardware set beats a clear.
module rc_sticky_bit #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic set_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic q_o
);
    // Hold the flag; power-on loads RESET_VAL, cause sets, write-0 clears
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q_o <= RESET_VAL;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (wr_i && !wbit_i) begin
            q_o <= 1'b0;
        end
    end
endmodule

// File: rtl/rc_read_port.sv
// Module: rc_read_port
// Forms read data: flags in the low bits on a hit, zero otherwise.
// Assumes reserved upper bits always read as zero.
module rc_read_port
    import rc_pkg::*;
(
    input  logic             rd_hit_i,
    input  cause_vec_t       flags_i,
    output logic [REG_W-1:0] rdata_o
);
    // Zero-extend the flags onto the data bus when the read hits
    always_comb begin
        rdata_o = '0;
        if (rd_hit_i) begin
            rdata_o[NUM_CAUSES-1:0] = flags_i;
        end
    end
endmodule

// File: rtl/reset_cause_recorder.sv
// Module: reset_cause_recorder
// Records which reset causes have occurred in sticky flags that survive every
// reset but power-on, and exposes them through one 32-bit register.
// Assumes cause inputs are single-cycle pulses synchronous to clk and that
// por_n is the only reset applied to this block.
module reset_cause_recorder
    import rc_pkg::*;
#(
    parameter int                ADDR_W       = 12,
    parameter logic [ADDR_W-1:0] CAUSE_OFFSET = 'h05C
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              ext_rst_pulse,
    input  logic              bor_rst_pulse,
    input  logic              wdt_rst_pulse,
    input  logic              sw_rst_pulse,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_rd_en,
    output logic [REG_W-1:0]  reg_rdata
);
    logic       rd_hit;
    logic       wr_hit;
    cause_vec_t set_vec;
    cause_vec_t flags;
    logic       unused_wdata_hi;

    // Reserved write bits are deliberately discarded
    assign unused_wdata_hi = ^reg_wdata[REG_W-1:NUM_CAUSES];

    // Gather cause pulses at their flag positions; power-on has no pulse
    always_comb begin
        set_vec          = '0;
        set_vec[IDX_EXT] = ext_rst_pulse;
        set_vec[IDX_BOR] = bor_rst_pulse;
        set_vec[IDX_WDT] = wdt_rst_pulse;
        set_vec[IDX_SW]  = sw_rst_pulse;
    end

    rc_addr_match #(
        .ADDR_W (ADDR_W),
        .OFFSET (CAUSE_OFFSET)
    ) u_match (
        .addr_i   (reg_addr),
        .rd_en_i  (reg_rd_en),
        .wr_en_i  (reg_wr_en),
        .rd_hit_o (rd_hit),
        .wr_hit_o (wr_hit)
    );

    for (genvar i = 0; i < NUM_CAUSES; i++) begin : g_flag
        rc_sticky_bit #(
            .RESET_VAL (POR_FLAGS[i])
        ) u_bit (
            .clk    (clk),
            .por_n  (por_n),
            .set_i  (set_vec[i]),
            .wr_i   (wr_hit),
            .wbit_i (reg_wdata[i]),
            .q_o    (flags[i])
        );
    end

    rc_read_port u_read (
        .rd_hit_i (rd_hit),
        .flags_i  (flags),
        .rdata_o  (reg_rdata)
    );
endmodule

// File: rtl/rc_checker.sv
// Module: rc_checker
// Property checks for reset_cause_recorder, attached through bind.
// Assumes it sees the top-level ports plus the internal flag vector.
module rc_checker
    import rc_pkg::*;
#(
    parameter int                ADDR_W = 12,
    parameter logic [ADDR_W-1:0] OFFSET = 'h05C
) (
    input logic              clk,
    input logic              por_n,
    input logic              ext_rst_pulse,
    input logic              bor_rst_pulse,
    input logic              wdt_rst_pulse,
    input logic              sw_rst_pulse,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr_en,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              reg_rd_en,
    input logic [REG_W-1:0]  reg_rdata,
    input cause_vec_t        flags
);
    logic       chk_wr_hit;
    logic       chk_rd_hit;
    logic       any_pulse;

    assign chk_wr_hit = reg_wr_en && (reg_addr == OFFSET);
    assign chk_rd_hit = reg_rd_en && (reg_addr == OFFSET);
    assign any_pulse  = ext_rst_pulse || bor_rst_pulse || wdt_rst_pulse || sw_rst_pulse;

    assert_por_value_R1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(por_n) |-> flags == POR_FLAGS);

    assert_ext_sets_R2: assert property (@(posedge clk) disable iff (!por_n)
        ext_rst_pulse |=> flags[IDX_EXT]);

    assert_sw_sets_R2: assert property (@(posedge clk) disable iff (!por_n)
        sw_rst_pulse |=> flags[IDX_SW]);

    assert_sticky_R3: assert property (@(posedge clk) disable iff (!por_n)
        !chk_wr_hit |=> ($past(flags) & ~flags) == '0);

    assert_all_set_R4: assert property (@(posedge clk) disable iff (!por_n)
        (wdt_rst_pulse && bor_rst_pulse) |=> (flags[IDX_WDT] && flags[IDX_BOR]));

    assert_write_clear_R5: assert property (@(posedge clk) disable iff (!por_n)
        (chk_wr_hit && !any_pulse) |=> flags == ($past(flags) & $past(reg_wdata[NUM_CAUSES-1:0])));

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!por_n)
        (chk_wr_hit && wdt_rst_pulse) |=> flags[IDX_WDT]);

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!por_n)
        reg_rdata[REG_W-1:NUM_CAUSES] == '0);

    assert_read_value_R7: assert property (@(posedge clk) disable iff (!por_n)
        chk_rd_hit |-> reg_rdata[NUM_CAUSES-1:0] == flags);

    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!por_n)
        !chk_rd_hit |-> reg_rdata == '0);
endmodule

bind reset_cause_recorder rc_checker #(
    .ADDR_W (ADDR_W),
    .OFFSET (CAUSE_OFFSET)
) u_chk (
    .clk           (clk),
    .por_n         (por_n),
    .ext_rst_pulse (ext_rst_pulse),
    .bor_rst_pulse (bor_rst_pulse),
    .wdt_rst_pulse (wdt_rst_pulse),
    .sw_rst_pulse  (sw_rst_pulse),
    .reg_addr      (reg_addr),
    .reg_wr_en     (reg_wr_en),
    .reg_wdata     (reg_wdata),
    .reg_rd_en     (reg_rd_en),
    .reg_rdata     (reg_rdata),
    .flags         (flags)
);

// File: tb/reset_cause_recorder_test.sv
// Bench: sweeps cause-pulse combinations against write masks and checks the
// register read-back against an arithmetic model of the flags.
module reset_cause_recorder_test;
    localparam int          CLK_PERIOD = 10;
    localparam int          ADDR_W     = 12;
    localparam logic [11:0] OFFS       = 12'h05C;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        ext_p = 1'b0, bor_p = 1'b0, wdt_p = 1'b0, sw_p = 1'b0;
    logic [11:0] addr = 12'h000;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;

    int   vectors = 0;
    int   miscompares = 0;
    logic [4:0] exp_flags;

    always #(CLK_PERIOD/2) clk = ~clk;

    reset_cause_recorder #(.ADDR_W(ADDR_W), .CAUSE_OFFSET(OFFS)) uut (
        .clk(clk), .por_n(por_n),
        .ext_rst_pulse(ext_p), .bor_rst_pulse(bor_p),
        .wdt_rst_pulse(wdt_p), .sw_rst_pulse(sw_p),
        .reg_addr(addr), .reg_wr_en(wr_en), .reg_wdata(wdata),
        .reg_rd_en(rd_en), .reg_rdata(rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (act !== expv) begin
            miscompares++;
            $display("FAIL %s: got %08h expected %08h", tag, act, expv);
        end
    endtask

    // Map pulse vector {sw,wdt,bor,ext} to flag positions
    function automatic logic [4:0] pulse_bits(input logic [3:0] p);
        return {p[3], p[2], p[1], 1'b0, p[0]};
    endfunction

    // Apply one clock of stimulus, then release strobes between edges
    task automatic step(input logic [3:0] p, input logic wr, input logic [11:0] a,
                        input logic [31:0] wd);
        @(negedge clk);
        {sw_p, wdt_p, bor_p, ext_p} = p;
        wr_en = wr; addr = a; wdata = wd;
        @(posedge clk);
        #1;
        {sw_p, wdt_p, bor_p, ext_p} = 4'b0;
        wr_en = 1'b0; wdata = 32'h0;
    endtask

    // Read the register between edges and compare with the model
    task automatic read_check(input string tag);
        addr = OFFS; rd_en = 1'b1;
        #1;
        check(tag, rdata, {27'b0, exp_flags});
        rd_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        exp_flags = 5'b00010;
        // R1: value during and right after power-on
        #(CLK_PERIOD * 2 + 2);
        read_check("R1 during por");
        @(negedge clk); por_n = 1'b1;
        @(posedge clk); #2;
        read_check("R1 after por");

        // R2 and R3: single causes, one at a time, accumulate
        step(4'b0001, 1'b0, OFFS, 32'h0); exp_flags |= pulse_bits(4'b0001);
        read_check("R2 ext");
        step(4'b0100, 1'b0, OFFS, 32'h0); exp_flags |= pulse_bits(4'b0100);
        read_check("R3 wdt keeps ext");
        step(4'b0000, 1'b0, OFFS, 32'h0);
        read_check("R3 hold");

        // Sweep: every pulse set against every write mask, write on and off
        for (int w = 0; w < 2; w++) begin
            for (int p = 0; p < 16; p++) begin
                for (int m = 0; m < 32; m++) begin
                    string tag;
                    logic [3:0] pv;
                    pv = 4'(p);
                    tag = (w == 1 && p != 0) ? "R6" : (w == 1) ? "R5" :
                          ($countones(pv) > 1) ? "R4" : "R2";
                    step(pv, 1'(w), OFFS, {27'h7FFFFFF, 5'(m)});
                    if (w == 1) exp_flags &= 5'(m);
                    exp_flags |= pulse_bits(pv);
                    read_check(tag);
                end
            end
        end

        // R7: reserved write bits ignored, reserved read bits zero
        step(4'b0000, 1'b1, OFFS, 32'hFFFF_FFE0); exp_flags = 5'b0;
        read_check("R7 clear all, reserved ones");
        step(4'b1111, 1'b0, OFFS, 32'h0); exp_flags = 5'b11101;
        read_check("R7 reserved read zero");

        // R8: other offsets and no strobe
        step(4'b0000, 1'b1, 12'h058, 32'h0);
        read_check("R8 write other offset");
        addr = 12'h060; rd_en = 1'b1; #1;
        check("R8 read other offset", rdata, 32'h0);
        addr = OFFS; rd_en = 1'b0; #1;
        check("R8 no strobe", rdata, 32'h0);

        // R9: power-on mid-run with pulses active
        @(negedge clk);
        {sw_p, wdt_p, bor_p, ext_p} = 4'b1111;
        por_n = 1'b0;
        exp_flags = 5'b00010;
        @(posedge clk); #1;
        read_check("R9 during por");
        @(negedge clk);
        {sw_p, wdt_p, bor_p, ext_p} = 4'b0;
        por_n = 1'b1;
        @(posedge clk); #1;
        read_check("R9 after por");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule